// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell

This block is one output cell of a programmable sum-of-products device. The array delivers a vector of product terms. The cell ORs them into a single sum. Two configuration bits set the cell up in one of two ways:

- It can latch the sum in a flip-flop or pass it straight through.
- It can drive the pin true or inverted.

A separate enable product term decides whether the cell drives its bidirectional pin. The pin is modelled as a data output, an enable output and a sensed pin-input. The cell also returns one feedback bit to the array. In registered mode that bit is the flip-flop state, so the cell can hold state-machine state. In combinational mode it is the sensed pin level, so the pin can also be used as an input.

A complete device is built from ten of these cells sharing one array. All ten cells receive the same initialisation controls:

- a shared clear term that acts asynchronously;
- a shared set term that acts on the next clock edge;
- an active-low power-up clear;
- a test load path that forces any chosen value into the flip-flop, whatever the array computes.

Top module: `outCell`

## Requirements
- R1: `cfgMode` selects the operation: bit 1 = 0 gives registered and bit 1 = 1 gives combinational; bit 0 = 1 gives active-high and bit 0 = 0 gives active-low (00 registered/low, 01 registered/high, 10 combinational/low, 11 combinational/high).
- R2: With no clear, set or test load active, the flip-flop takes the OR of all bits of `termVec` on each rising clock edge.
- R3: In combinational mode `pinOut` follows the OR of `termVec` with no clock edge needed, with the polarity of R4 applied.
- R4: Inversion is applied after the flip-flop: in active-low mode `pinOut` is the complement of the selected source, so a cleared flip-flop drives `pinOut` high in mode 00.
- R5: `pinOe` equals `oeTerm` at all times, and the value on `pinOut` does not depend on `oeTerm`.
- R6: In registered mode `fbOut` equals the flip-flop state, whatever `oeTerm` and `pinIn` are.
- R7: In combinational mode `fbOut` equals `pinIn`.
- R8: A high `asyncClr` clears the flip-flop at once, without waiting for a clock edge, and holds it clear.
- R9: A high `syncSet` sets the flip-flop to 1 on the next rising edge.
- R10: When `asyncClr` and `syncSet` are both high, the flip-flop stays clear.
- R11: A low `porN` clears the flip-flop asynchronously.
- R12: A high `preloadEn` loads `preloadVal` on the next rising edge, taking priority over `syncSet` and over the array sum. Both clear inputs still take priority over the test load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flop |
| porN | input | 1 | Power-up clear, active low, asynchronous |
| asyncClr | input | 1 | Shared clear term, asynchronous |
| syncSet | input | 1 | Shared set term, takes effect on the next clock edge |
| preloadEn | input | 1 | Test load strobe |
| preloadVal | input | 1 | Value written by a test load |
| cfgMode | input | 2 | Mode select: bit 1 = combinational, bit 0 = active-high |
| termVec | input | NUM_TERMS | Product terms from the array |
| oeTerm | input | 1 | Output enable product term |
| pinIn | input | 1 | Level sensed on the pin |
| pinOut | output | 1 | Data presented to the pin driver |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback bit to the array |

## Verification
The collisions that matter happen at a single clock edge. There, the test load, the shared set, the shared clear and a changing array sum all compete for the one flip-flop. The bench drives every pairing in the same cycle: set together with a non-zero sum, test load together with set, and clear together with set and with test load. After each such edge it compares the feedback bit and the pin data against a behavioural priority model. The asynchronous clear is also applied in the middle of a cycle. The outputs are checked before the next edge, which shows that the clear acts without a clock.

// File: rtl/outCellPkg.sv
`timescale 1ns/1ps
package outCellPkg;

  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } cellMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrNow;   // asynchronous clear of the cell flip-flop
    logic loadPre;  // take the test load value at the edge
    logic loadSet;  // take a 1 at the edge
    logic loadSum;  // take the array sum at the edge
    logic selComb;  // bypass the flip-flop
    logic invOut;   // drive the complement
  } cellStrobes_t;

endpackage

// File: rtl/outCellCtrl.sv
`timescale 1ns/1ps
module outCellCtrl
  import outCellPkg::*;
(
  input  logic         porN,
  input  logic         asyncClr,
  input  logic         syncSet,
  input  logic         preloadEn,
  input  logic [1:0]   cfgMode,
  output cellStrobes_t stb
);

  cellMode_e modeSel;

  always_comb begin
    modeSel = cellMode_e'(cfgMode);
    stb = '0;
    // both clear sources act asynchronously and outrank everything
    stb.clrNow = asyncClr | ~porN;
    // edge loads in priority order: test load, then set, then the array sum
    if (preloadEn)    stb.loadPre = 1'b1;
    else if (syncSet) stb.loadSet = 1'b1;
    else              stb.loadSum = 1'b1;
    unique case (modeSel)
      MODE_REG_LOW:   begin stb.selComb = 1'b0; stb.invOut = 1'b1; end
      MODE_REG_HIGH:  begin stb.selComb = 1'b0; stb.invOut = 1'b0; end
      MODE_COMB_LOW:  begin stb.selComb = 1'b1; stb.invOut = 1'b1; end
      MODE_COMB_HIGH: begin stb.selComb = 1'b1; stb.invOut = 1'b0; end
      default:        begin stb.selComb = 1'b0; stb.invOut = 1'b0; end
    endcase
  end

endmodule

// File: rtl/outCellDatapath.sv
`timescale 1ns/1ps
module outCellDatapath
  import outCellPkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  cellStrobes_t         stb,
  input  logic [NUM_TERMS-1:0] termVec,
  input  logic                 preloadVal,
  input  logic                 oeTerm,
  input  logic                 pinIn,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbOut
);

  localparam int CHAIN_LEN = NUM_TERMS + 1;

  logic [CHAIN_LEN-1:0] orChain;
  logic sumTerm;
  logic cellQ;
  logic nextQ;
  logic clrNow;
  logic srcBit;

  // OR of the product terms, built as a chain
  assign orChain[0] = 1'b0;
  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_sum
    assign orChain[i+1] = orChain[i] | termVec[i];
  end
  assign sumTerm = orChain[CHAIN_LEN-1];

  assign clrNow = stb.clrNow;

  always_comb begin
    nextQ = cellQ;
    if (stb.loadPre)      nextQ = preloadVal;
    else if (stb.loadSet) nextQ = 1'b1;
    else if (stb.loadSum) nextQ = sumTerm;
  end

  always_ff @(posedge clk or posedge clrNow) begin
    if (clrNow) cellQ <= 1'b0;
    else        cellQ <= nextQ;
  end

  // polarity is applied after the flip-flop / bypass select
  assign srcBit = stb.selComb ? sumTerm : cellQ;
  assign pinOut = srcBit ^ stb.invOut;
  assign pinOe  = oeTerm;
  assign fbOut  = stb.selComb ? pinIn : cellQ;

endmodule

// File: rtl/outCell.sv
`timescale 1ns/1ps
module outCell
  import outCellPkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 asyncClr,
  input  logic                 syncSet,
  input  logic                 preloadEn,
  input  logic                 preloadVal,
  input  logic [1:0]           cfgMode,
  input  logic [NUM_TERMS-1:0] termVec,
  input  logic                 oeTerm,
  input  logic                 pinIn,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbOut
);

  cellStrobes_t stb;

  outCellCtrl i_ctrl (
    .porN      (porN),
    .asyncClr  (asyncClr),
    .syncSet   (syncSet),
    .preloadEn (preloadEn),
    .cfgMode   (cfgMode),
    .stb       (stb)
  );

  outCellDatapath #(.NUM_TERMS(NUM_TERMS)) i_dp (
    .clk        (clk),
    .stb        (stb),
    .termVec    (termVec),
    .preloadVal (preloadVal),
    .oeTerm     (oeTerm),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .fbOut      (fbOut)
  );

endmodule

// File: rtl/outCellChecker.sv
`timescale 1ns/1ps
module outCellChecker (
  input logic       clk,
  input logic       porN,
  input logic       asyncClr,
  input logic       syncSet,
  input logic       preloadEn,
  input logic       preloadVal,
  input logic [1:0] cfgMode,
  input logic       pinIn,
  input logic       pinOut,
  input logic       fbOut
);

  // registered mode: pin data is the feedback state, inverted when active-low
  assert_reg_polarity_R4: assert property (@(posedge clk) disable iff (!porN)
    !cfgMode[1] |-> (pinOut == (cfgMode[0] ? fbOut : !fbOut)));

  assert_comb_feedback_R7: assert property (@(posedge clk) disable iff (!porN)
    cfgMode[1] |-> (fbOut == pinIn));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!porN)
    (asyncClr && !cfgMode[1]) |-> !fbOut);

  assert_powerup_clear_R11: assert property (@(posedge clk) disable iff (asyncClr)
    (!porN && !cfgMode[1]) |-> !fbOut);

  assert_preset_R9: assert property (@(posedge clk) disable iff (!porN || asyncClr)
    ($past(porN) && !$past(asyncClr) && $past(syncSet) && !$past(preloadEn)
     && !cfgMode[1]) |-> fbOut);

  assert_preload_R12: assert property (@(posedge clk) disable iff (!porN || asyncClr)
    ($past(porN) && !$past(asyncClr) && $past(preloadEn) && !cfgMode[1])
    |-> (fbOut == $past(preloadVal)));

endmodule

bind outCell outCellChecker i_outCellChecker (
  .clk        (clk),
  .porN       (porN),
  .asyncClr   (asyncClr),
  .syncSet    (syncSet),
  .preloadEn  (preloadEn),
  .preloadVal (preloadVal),
  .cfgMode    (cfgMode),
  .pinIn      (pinIn),
  .pinOut     (pinOut),
  .fbOut      (fbOut)
);

// File: tb/test_outCell.sv
`timescale 1ns/1ps
module test_outCell;

  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          asyncClr = 1'b0;
  logic          syncSet = 1'b0;
  logic          preloadEn = 1'b0;
  logic          preloadVal = 1'b0;
  logic [1:0]    cfgMode = 2'b00;
  logic [NT-1:0] termVec = '0;
  logic          oeTerm = 1'b0;
  logic          pinIn = 1'b0;
  logic          pinOut, pinOe, fbOut;

  int vecCount = 0;
  int errCount = 0;
  bit modelQ = 1'b0;

  always #5 clk = ~clk;

  outCell #(.NUM_TERMS(NT)) i_outCell (
    .clk(clk), .porN(porN), .asyncClr(asyncClr), .syncSet(syncSet),
    .preloadEn(preloadEn), .preloadVal(preloadVal), .cfgMode(cfgMode),
    .termVec(termVec), .oeTerm(oeTerm), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare mid-cycle, advance model at posedge
  task automatic step(input string tag, input logic por, input logic clr,
                      input logic set, input logic pre, input logic pv,
                      input logic [1:0] mode, input logic [NT-1:0] terms,
                      input logic oe, input logic pin);
    bit comb, high, sum, expOut, expFb;
    @(negedge clk);
    porN = por; asyncClr = clr; syncSet = set; preloadEn = pre;
    preloadVal = pv; cfgMode = mode; termVec = terms; oeTerm = oe; pinIn = pin;
    if (clr || !por) modelQ = 1'b0;
    comb = mode[1];
    high = mode[0];
    sum = (terms != '0);
    expOut = (comb ? sum : modelQ) ? high : !high;
    expFb  = comb ? pin : modelQ;
    #1;
    cmp(tag, "pinOut", pinOut, expOut);
    cmp(tag, "pinOe", pinOe, oe);
    cmp(tag, "fbOut", fbOut, expFb);
    @(posedge clk);
    if (!(clr || !por)) begin
      if (pre)      modelQ = pv;
      else if (set) modelQ = 1'b1;
      else          modelQ = sum;
    end
  endtask

  initial begin
    #1_000_000;
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    // R11: power-up clear; R4: cleared register drives pin high in mode 00
    step("R11", 0, 0, 0, 0, 0, 2'b00, 8'hFF, 1, 1);
    step("R11", 0, 0, 1, 1, 1, 2'b00, 8'hFF, 0, 1);
    step("R4",  1, 0, 0, 0, 0, 2'b00, 8'h00, 1, 1);
    // R2: capture array sum, active-high registered; R6: fb ignores oe/pin
    step("R2", 1, 0, 0, 0, 0, 2'b01, 8'h10, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 2'b01, 8'h00, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 2'b01, 8'h80, 1, 1);
    step("R2", 1, 0, 0, 0, 0, 2'b00, 8'h01, 0, 1);
    step("R4", 1, 0, 0, 0, 0, 2'b00, 8'h00, 1, 0);
    // R9: preset sets even with zero sum
    step("R9", 1, 0, 1, 0, 0, 2'b01, 8'h00, 1, 0);
    step("R9", 1, 0, 0, 0, 0, 2'b01, 8'h00, 1, 0);
    // R8: async clear mid-cycle
    step("R2", 1, 0, 0, 0, 0, 2'b01, 8'h04, 1, 0);
    step("R8", 1, 1, 0, 0, 0, 2'b01, 8'hFF, 1, 0);
    // R10: clear and set together
    step("R10", 1, 1, 1, 0, 0, 2'b01, 8'hFF, 1, 0);
    step("R10", 1, 0, 0, 0, 0, 2'b01, 8'h00, 1, 0);
    // R12: preload beats preset and sum; clear beats preload
    step("R12", 1, 0, 1, 1, 0, 2'b01, 8'hFF, 0, 1);
    step("R12", 1, 0, 0, 1, 1, 2'b00, 8'h00, 0, 0);
    step("R12", 1, 1, 0, 1, 1, 2'b01, 8'h00, 0, 0);
    step("R12", 1, 0, 0, 0, 0, 2'b01, 8'h00, 0, 0);
    // R3/R7: combinational modes, pin feedback, R5 enable passthrough
    step("R3", 1, 0, 0, 0, 0, 2'b11, 8'h20, 0, 1);
    step("R3", 1, 0, 0, 0, 0, 2'b10, 8'h20, 1, 0);
    step("R7", 1, 0, 0, 0, 0, 2'b11, 8'h00, 0, 1);
    step("R5", 1, 0, 0, 0, 0, 2'b10, 8'h00, 1, 1);
    // R1: cycle all mode encodings with mixed stimulus
    for (int k = 0; k < 200; k++) begin
      logic [NT-1:0] tv;
      tv = NT'($urandom) & NT'($urandom);
      step("R1", 1, ($urandom % 13) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
           1'($urandom), 2'(k % 4), tv, 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule